// File: doc/BRIEF.md
# Floating-Point Select Execution Unit

This block executes a branch-free floating-point select operation on 64-bit double-precision operands. It takes a 32-bit instruction word with a valid strobe and decodes the word into its register and control fields. It reads three sources from a 32-entry floating-point register file. One source, the key, is classified by its bits alone, with no IEEE comparator. The destination receives the second-listed source (C) when the key is greater than or equal to zero, and the other source (B) when it is not. Negative zero takes the C path. Every NaN takes the B path.

The selected value is copied bit for bit, and no floating-point status is ever changed. When the record flag in the instruction is set, the unit loads four summary bits taken from the status register into a 4-bit condition field. An instruction word that does not match the select encoding raises a one-cycle illegal pulse and writes nothing.

A test write port loads the register file, and a combinational test read port lets the contents be observed.

Top module: `fsel_unit`

## Requirements
- R1: Instruction bits, numbered so that [31] is the MSB of the port: [31:26] primary opcode, [25:21] destination, [20:16] source A, [15:11] source B, [10:6] source C, [5:1] extended opcode, [0] record flag. An instruction executes only when the primary opcode is 63 and the extended opcode is 23. `res_dest` then equals the destination field.
- R2: A key (source A) with sign 0 that is not a NaN selects source C. This includes +0, positive subnormals and +infinity. A key with sign 1 that is neither zero nor NaN selects source B.
- R3: A key of -0 (sign 1, exponent 0, fraction 0) selects source C.
- R4: A key with exponent 0x7FF and a nonzero fraction selects source B, whatever its sign.
- R5: The selected 64-bit value appears unchanged on `res_data` and is written, unchanged, to the destination register.
- R6: With record flag 1, `cr_field` is loaded with `stat_sum`, where bit 3 is FX, bit 2 is FEX, bit 1 is VX and bit 0 is OX.
- R7: With record flag 0, `cr_field` keeps its value.
- R8: `issue_valid` with a non-matching opcode gives `res_illegal`=1 and `res_valid`=0 for one cycle. It leaves both the register file and `cr_field` unchanged.
- R9: Results, the register write and the condition update all take effect on the first clock edge after `issue_valid` is sampled. When `issue_valid` is low, `res_valid` and `res_illegal` are 0 in the next cycle.
- R10: Synchronous reset clears `res_valid`, `res_illegal` and `cr_field` to 0.
- R11: `tw_en` writes `tw_data` into register `tw_addr` at the clock edge. `tr_data` shows register `tr_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction strobe |
| issue_word | input | 32 | Instruction word |
| stat_sum | input | 4 | Status summary bits {FX,FEX,VX,OX} |
| tw_en | input | 1 | Test write enable |
| tw_addr | input | 5 | Test write register index |
| tw_data | input | 64 | Test write data |
| tr_addr | input | 5 | Test read register index |
| tr_data | output | 64 | Test read data |
| res_valid | output | 1 | Select executed (one-cycle pulse) |
| res_illegal | output | 1 | Non-matching opcode (one-cycle pulse) |
| res_dest | output | 5 | Destination register of the executed select |
| res_data | output | 64 | Selected value |
| cr_field | output | 4 | Condition field updated by the record form |

## Verification
Every result of this block is due exactly one edge after `issue_valid` is sampled. This covers the valid and illegal pulses, the result data, the register write and the condition field. The bench drives each instruction on a falling edge and inspects all outputs on the next falling edge, half a cycle after they change. It then reads the destination through the test read port in that same cycle. Before the bench checks that the pulses have dropped, it waits one further full cycle with the strobe low.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
    localparam int XLEN    = 64;
    localparam int EXP_W   = 11;
    localparam int FRAC_W  = 52;
    localparam int REG_AW  = 5;
    localparam int NREG    = 1 << REG_AW;
    localparam int IW      = 32;
    localparam int PRI_W   = 6;
    localparam int XO_W    = 5;
    localparam int CR_W    = 4;
    localparam logic [PRI_W-1:0] PRI_SEL = 6'd63;
    localparam logic [XO_W-1:0]  EXT_SEL = 5'd23;
    localparam logic [EXP_W-1:0] EXP_ALL1 = '1;

    typedef struct packed {
        logic [PRI_W-1:0]  pri;
        logic [REG_AW-1:0] rt;
        logic [REG_AW-1:0] ra;
        logic [REG_AW-1:0] rb;
        logic [REG_AW-1:0] rc;
        logic [XO_W-1:0]   xo;
        logic              rec;
    } sel_word_t;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [FRAC_W-1:0] frac;
    } dbl_t;

    typedef enum logic [1:0] {
        KEY_NONNEG = 2'd0,
        KEY_NEG    = 2'd1,
        KEY_ZERO   = 2'd2,
        KEY_NAN    = 2'd3
    } key_class_e;

    function automatic key_class_e classify_key(input dbl_t v);
        if (v.expo == EXP_ALL1 && v.frac != '0)
            return KEY_NAN;
        else if (v.expo == '0 && v.frac == '0)
            return KEY_ZERO;
        else if (v.sign)
            return KEY_NEG;
        else
            return KEY_NONNEG;
    endfunction
endpackage

// File: rtl/fsel_decode.sv
module fsel_decode
    import fsel_pkg::*;
(
    input  logic [IW-1:0] word,
    output sel_word_t     fields,
    output logic          is_sel
);
    always_comb begin
        fields = sel_word_t'(word);
        is_sel = (fields.pri == PRI_SEL) && (fields.xo == EXT_SEL);
    end
endmodule

// File: rtl/fsel_key_class.sv
module fsel_key_class
    import fsel_pkg::*;
(
    input  logic [XLEN-1:0] key,
    output key_class_e      cls,
    output logic            take_c
);
    always_comb begin
        cls    = classify_key(dbl_t'(key));
        take_c = (cls == KEY_NONNEG) || (cls == KEY_ZERO);
    end
endmodule

// File: rtl/fsel_regfile.sv
module fsel_regfile
    import fsel_pkg::*;
(
    input  logic              clk,
    input  logic              ex_we,
    input  logic [REG_AW-1:0] ex_waddr,
    input  logic [XLEN-1:0]   ex_wdata,
    input  logic              tw_en,
    input  logic [REG_AW-1:0] tw_addr,
    input  logic [XLEN-1:0]   tw_data,
    input  logic [REG_AW-1:0] ra_a,
    input  logic [REG_AW-1:0] ra_b,
    input  logic [REG_AW-1:0] ra_c,
    input  logic [REG_AW-1:0] ra_t,
    output logic [XLEN-1:0]   rd_a,
    output logic [XLEN-1:0]   rd_b,
    output logic [XLEN-1:0]   rd_c,
    output logic [XLEN-1:0]   rd_t
);
    logic [XLEN-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (ex_we)
            mem[ex_waddr] <= ex_wdata;
        if (tw_en && !(ex_we && ex_waddr == tw_addr))
            mem[tw_addr] <= tw_data;
    end

    always_comb begin
        rd_a = mem[ra_a];
        rd_b = mem[ra_b];
        rd_c = mem[ra_c];
        rd_t = mem[ra_t];
    end
endmodule

// File: rtl/fsel_unit.sv
module fsel_unit
    import fsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  logic [IW-1:0]     issue_word,
    input  logic [CR_W-1:0]   stat_sum,
    input  logic              tw_en,
    input  logic [REG_AW-1:0] tw_addr,
    input  logic [XLEN-1:0]   tw_data,
    input  logic [REG_AW-1:0] tr_addr,
    output logic [XLEN-1:0]   tr_data,
    output logic              res_valid,
    output logic              res_illegal,
    output logic [REG_AW-1:0] res_dest,
    output logic [XLEN-1:0]   res_data,
    output logic [CR_W-1:0]   cr_field
);
    sel_word_t       f;
    logic            is_sel;
    logic            exec;
    logic [XLEN-1:0] src_a, src_b, src_c, pick;
    key_class_e      key_cls;
    logic            take_c;

    fsel_decode u_dec (
        .word   (issue_word),
        .fields (f),
        .is_sel (is_sel)
    );

    assign exec = issue_valid && is_sel;

    fsel_regfile u_rf (
        .clk      (clk),
        .ex_we    (exec),
        .ex_waddr (f.rt),
        .ex_wdata (pick),
        .tw_en    (tw_en),
        .tw_addr  (tw_addr),
        .tw_data  (tw_data),
        .ra_a     (f.ra),
        .ra_b     (f.rb),
        .ra_c     (f.rc),
        .ra_t     (tr_addr),
        .rd_a     (src_a),
        .rd_b     (src_b),
        .rd_c     (src_c),
        .rd_t     (tr_data)
    );

    fsel_key_class u_cls (
        .key    (src_a),
        .cls    (key_cls),
        .take_c (take_c)
    );

    assign pick = take_c ? src_c : src_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_illegal <= 1'b0;
            cr_field    <= '0;
            res_dest    <= '0;
            res_data    <= '0;
        end else begin
            res_valid   <= exec;
            res_illegal <= issue_valid && !is_sel;
            if (exec) begin
                res_dest <= f.rt;
                res_data <= pick;
                if (f.rec)
                    cr_field <= stat_sum;
            end
        end
    end

    // R8
    illegal_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !is_sel) |=> (res_illegal && !res_valid && $stable(cr_field)));

    // R7
    cr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(issue_valid && is_sel && f.rec) |=> $stable(cr_field));

    // R6
    cr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && is_sel && f.rec) |=> (cr_field == $past(stat_sum)));

    // R4
    nan_false_path_chk: assert property (@(posedge clk) disable iff (rst)
        (exec && key_cls == KEY_NAN) |=> (res_data == $past(src_b)));

    // R3
    zero_true_path_chk: assert property (@(posedge clk) disable iff (rst)
        (exec && key_cls == KEY_ZERO) |=> (res_data == $past(src_c)));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |=> (!res_valid && !res_illegal));

    // R8
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({res_valid, res_illegal}));
endmodule

// File: tb/tb_fsel_unit.sv
`timescale 1ns/1ps
module tb_fsel_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        issue_valid;
    logic [31:0] issue_word;
    logic [3:0]  stat_sum;
    logic        tw_en;
    logic [4:0]  tw_addr;
    logic [63:0] tw_data;
    logic [4:0]  tr_addr;
    logic [63:0] tr_data;
    logic        res_valid, res_illegal;
    logic [4:0]  res_dest;
    logic [63:0] res_data;
    logic [3:0]  cr_field;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fsel_unit dut (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_word(issue_word),
        .stat_sum(stat_sum), .tw_en(tw_en), .tw_addr(tw_addr), .tw_data(tw_data),
        .tr_addr(tr_addr), .tr_data(tr_data), .res_valid(res_valid),
        .res_illegal(res_illegal), .res_dest(res_dest), .res_data(res_data),
        .cr_field(cr_field)
    );

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rt,
                                       input logic [4:0] ra, input logic [4:0] rb,
                                       input logic [4:0] rc, input logic [4:0] xo,
                                       input logic rec);
        return {op, rt, ra, rb, rc, xo, rec};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_reg(input logic [4:0] a, input logic [63:0] d);
        @(negedge clk);
        tw_en = 1'b1; tw_addr = a; tw_data = d;
        @(negedge clk);
        tw_en = 1'b0;
    endtask

    // drive at a falling edge; outputs are inspected at the next falling edge
    task automatic issue(input logic [31:0] w, input logic [3:0] s);
        @(negedge clk);
        issue_valid = 1'b1; issue_word = w; stat_sum = s;
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] keyv, bv, cv, expv;
        logic [3:0]  crv;
        rst = 1'b1; issue_valid = 0; issue_word = 0; stat_sum = 0;
        tw_en = 0; tw_addr = 0; tw_data = 0; tr_addr = 0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(res_valid == 0 && res_illegal == 0, "R10 flags", {62'd0, res_valid, res_illegal}, 0);
        chk(cr_field == 0, "R10 cr", {60'd0, cr_field}, 0);
        rst = 1'b0;

        // R11 test port
        put_reg(5'd7, 64'h0123_4567_89AB_CDEF);
        tr_addr = 5'd7; #1;
        chk(tr_data == 64'h0123_4567_89AB_CDEF, "R11 test write", tr_data, 64'h0123_4567_89AB_CDEF);

        // R2 R3 R4 R5 R12-style sweep over key classes
        for (int s = 0; s < 2; s++) begin
            for (int e = 0; e < 5; e++) begin
                for (int q = 0; q < 3; q++) begin
                    logic [10:0] ex;
                    logic [51:0] fr;
                    bit nan, zero, tc;
                    logic [4:0] dst;
                    case (e)
                        0: ex = 11'h000; 1: ex = 11'h001; 2: ex = 11'h3FF;
                        3: ex = 11'h7FE; default: ex = 11'h7FF;
                    endcase
                    fr = (q == 0) ? 52'd0 : (q == 1) ? 52'd1 : {52{1'b1}};
                    keyv = {s[0], ex, fr};
                    bv = {32'hB0B0_B0B0, 8'(s), 8'(e), 16'(q)};
                    cv = {32'hC0C0_C0C0, 8'(s), 8'(e), 16'(q)};
                    dst = 5'd10 + 5'(e);
                    nan  = (ex == 11'h7FF) && (fr != 0);
                    zero = (ex == 0) && (fr == 0);
                    tc   = !nan && (s == 0 || zero);
                    expv = tc ? cv : bv;
                    put_reg(5'd1, keyv);
                    put_reg(5'd2, bv);
                    put_reg(5'd3, cv);
                    tr_addr = dst;
                    issue(mk(6'd63, dst, 5'd1, 5'd2, 5'd3, 5'd23, 1'b0), 4'h0);
                    #1;
                    chk(res_valid == 1 && res_dest == dst, "R1 R9 valid/dest",
                        {58'd0, res_valid, res_dest}, {58'd0, 1'b1, dst});
                    if (nan)       chk(res_data == expv, "R4 nan key", res_data, expv);
                    else if (zero) chk(res_data == expv, s ? "R3 neg zero key" : "R2 pos zero key", res_data, expv);
                    else           chk(res_data == expv, "R2 signed key", res_data, expv);
                    chk(tr_data == expv, "R5 register written", tr_data, expv);
                end
            end
        end

        // R9 pulse drops when strobe is low
        @(negedge clk);
        chk(res_valid == 0 && res_illegal == 0, "R9 idle", {62'd0, res_valid, res_illegal}, 0);

        // R6 record form
        put_reg(5'd1, 64'h3FF0_0000_0000_0000);
        issue(mk(6'd63, 5'd20, 5'd1, 5'd2, 5'd3, 5'd23, 1'b1), 4'b1010);
        #1;
        chk(cr_field == 4'b1010, "R6 record load", {60'd0, cr_field}, 64'hA);
        issue(mk(6'd63, 5'd20, 5'd1, 5'd2, 5'd3, 5'd23, 1'b1), 4'b0101);
        #1;
        chk(cr_field == 4'b0101, "R6 record load 2", {60'd0, cr_field}, 64'h5);
        // R7 no record
        issue(mk(6'd63, 5'd20, 5'd1, 5'd2, 5'd3, 5'd23, 1'b0), 4'b1111);
        #1;
        chk(cr_field == 4'b0101, "R7 cr hold", {60'd0, cr_field}, 64'h5);
        chk(res_valid == 1, "R7 executed", {63'd0, res_valid}, 1);

        // R8 illegal encodings
        put_reg(5'd21, 64'hDEAD_BEEF_0000_1111);
        tr_addr = 5'd21;
        issue(mk(6'd63, 5'd21, 5'd1, 5'd2, 5'd3, 5'd22, 1'b1), 4'b1111);
        #1;
        chk(res_illegal == 1 && res_valid == 0, "R8 bad xo flags", {62'd0, res_illegal, res_valid}, 64'h2);
        chk(tr_data == 64'hDEAD_BEEF_0000_1111, "R8 bad xo reg", tr_data, 64'hDEAD_BEEF_0000_1111);
        chk(cr_field == 4'b0101, "R8 bad xo cr", {60'd0, cr_field}, 64'h5);
        issue(mk(6'd59, 5'd21, 5'd1, 5'd2, 5'd3, 5'd23, 1'b1), 4'b1111);
        #1;
        chk(res_illegal == 1 && res_valid == 0, "R8 bad primary flags", {62'd0, res_illegal, res_valid}, 64'h2);
        chk(tr_data == 64'hDEAD_BEEF_0000_1111, "R8 bad primary reg", tr_data, 64'hDEAD_BEEF_0000_1111);
        @(negedge clk);
        chk(res_illegal == 0, "R8 one-cycle pulse", {63'd0, res_illegal}, 0);

        // R9 matching word without strobe does nothing
        @(negedge clk);
        issue_word = mk(6'd63, 5'd21, 5'd1, 5'd2, 5'd3, 5'd23, 1'b1); stat_sum = 4'hF;
        @(negedge clk);
        chk(res_valid == 0, "R9 no strobe", {63'd0, res_valid}, 0);
        chk(tr_data == 64'hDEAD_BEEF_0000_1111, "R9 no strobe reg", tr_data, 64'hDEAD_BEEF_0000_1111);

        // R10 reset mid-run
        issue(mk(6'd63, 5'd20, 5'd1, 5'd2, 5'd3, 5'd23, 1'b1), 4'b0011);
        @(negedge clk);
        rst = 1'b1;
        issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
        chk(res_valid == 0 && cr_field == 0, "R10 reset clears", {59'd0, res_valid, cr_field}, 0);
        rst = 1'b0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule